// File: doc/BRIEF.md
# SDRAM Precharge Timing Scheduler

This block sits between a request front-end and the command bus of a four-bank SDR SDRAM controller whose bursts are always four beats long. Each request names an operation (activate, read, write or precharge), a bank and, for column operations, an auto-precharge flag. A request is held back until every timing rule for its bank allows it, and is then passed to the command outputs in the same cycle it is accepted. Only one request port exists, so at most one command leaves per cycle.

For each bank the block keeps an idle/open/precharging state, a write-recovery counter that starts after the last write data beat, and a precharge-recovery counter that starts when a precharge begins, whether that precharge was commanded or started internally by auto-precharge. A single burst tracker follows the burst now on the data bus. It lets a plain burst be cut short by a later column command. When a precharge is sent to a bank whose read burst is still running, the tracker truncates the burst and reports how many read beats will still appear on the data bus. That count depends on the selected CAS latency.

Top module: `sdram_pre_sched`

## Requirements
- R1: After reset every bank is idle. An activate to any bank is ready at once, and a read or write to any bank is not ready.
- R2: An activate (req_op 2'b00) is ready only when its bank is idle. Once it is accepted, the bank is open from the next cycle.
- R3: A read (2'b01) or write (2'b10) is ready only when its bank is open and no column block from R9 is in force.
- R4: For a write accepted in cycle t whose burst is not cut short, the last data beat is in cycle L = t+3. A precharge (2'b11) to that bank is not ready before cycle L+TRDL and is ready from that cycle on (TRDL = 2 by default).
- R5: If a precharge to an open bank is accepted in cycle p, the bank is precharging from p+1 on. An activate to it becomes ready in cycle p+TRP (TRP = 3 by default) and not earlier.
- R6: A precharge accepted k cycles (k = 1..3) after a plain read to the same bank ends that burst. In the same cycle trunc_valid pulses and trunc_beats gives min(k, CL-1) beats: always 1 at CAS latency 2 (cas_lat3 = 0), and up to 2 at CAS latency 3 (cas_lat3 = 1).
- R7: For a read with auto-precharge accepted in cycle t, the internal precharge begins in cycle t+4. An activate to that bank is ready from t+4+TRP.
- R8: For a write with auto-precharge accepted in cycle t, the internal precharge begins in cycle t+3+TRDL. An activate to that bank is ready from t+3+TRDL+TRP.
- R9: From the cycle after a column command with auto-precharge is accepted, a read or write to any bank is not ready. The block lasts up to and including the cycle before that command's internal precharge begins. In the cycle the precharge begins, an open bank accepts column commands again.
- R10: A precharge to a bank with a pending auto-precharge is never ready. A precharge to an idle bank is accepted and leaves the bank idle, so an activate to it is ready in the next cycle.
- R11: cmd_valid equals req_valid AND req_ready in the same cycle. While cmd_valid is high, cmd_op, cmd_bank and cmd_ap repeat the request.
- R12: A column command may cut short a plain burst to any bank. A write cut short in cycle c has its last data beat at c-1, and the R4 rule is counted from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat3 | input | 1 | 0 selects CAS latency 2, 1 selects CAS latency 3 |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 activate, 01 read, 10 write, 11 precharge |
| req_bank | input | 2 | Target bank |
| req_ap | input | 1 | Auto-precharge flag for read/write |
| req_ready | output | 1 | Request may issue this cycle |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | Issued operation |
| cmd_bank | output | 2 | Issued bank |
| cmd_ap | output | 1 | Issued auto-precharge flag |
| trunc_valid | output | 1 | A precharge has just cut a read burst short |
| trunc_beats | output | 2 | Read beats still delivered after that precharge |

## Verification
Two functions can fall in the same cycle. The internal precharge of a pending auto-precharge can begin in exactly the cycle in which a column command to another open bank, or an activate, is presented. The bench provokes this by holding such a request across the whole auto-precharge window at both CAS latencies, and by long random streams where it happens often. A behavioural model driven by absolute cycle numbers judges every cycle: it predicts the ready level, the command echo and any truncation report, and compares them with the design's ports.

// File: rtl/pre_sched_pkg.sv
package pre_sched_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_PRE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'b00,
    BK_ACTIVE = 2'b01,
    BK_PRECH  = 2'b10
  } bank_st_e;

  localparam int BURST_LEN = 4;

  // beats of a cut read that still reach the data bus: min(done, CL-1)
  function automatic logic [1:0] kept_beats(input logic [1:0] done, input logic cl3);
    logic [1:0] cap;
    cap = cl3 ? 2'd2 : 2'd1;
    return (done < cap) ? done : cap;
  endfunction

  // beats already on the bus before the current cycle, from beats still to come
  function automatic logic [1:0] beats_done(input logic [1:0] left);
    logic [2:0] d;
    d = 3'(BURST_LEN) - {1'b0, left};
    return d[1:0];
  endfunction
endpackage

// File: rtl/pre_burst_trk.sv
module pre_burst_trk #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_go,
  input  logic          col_wr,
  input  logic          col_ap,
  input  logic [BW-1:0] col_bank,
  input  logic          pre_go,
  input  logic [BW-1:0] pre_bank,
  output logic [1:0]    left_o,
  output logic [BW-1:0] bank_o,
  output logic          wr_o,
  output logic          ap_o,
  output logic          trunc_hit
);
  logic [1:0]    left_q;
  logic [BW-1:0] bank_q;
  logic          wr_q, ap_q, busy;

  assign busy      = (left_q != 2'd0);
  assign trunc_hit = pre_go && busy && !wr_q && (bank_q == pre_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= 2'd0;
      bank_q <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
    end else if (col_go) begin
      left_q <= 2'd3;
      bank_q <= col_bank;
      wr_q   <= col_wr;
      ap_q   <= col_ap;
    end else if (trunc_hit) begin
      left_q <= 2'd0;
    end else if (busy) begin
      left_q <= left_q - 2'd1;
    end
  end

  assign left_o = left_q;
  assign bank_o = bank_q;
  assign wr_o   = wr_q;
  assign ap_o   = ap_q;
endmodule

// File: rtl/pre_bank_trk.sv
module pre_bank_trk
  import pre_sched_pkg::*;
#(
  parameter int TRDL = 2,
  parameter int TRP  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_go,
  input  logic       pre_go,
  input  logic       col_go,
  input  logic       col_ap,
  input  logic       beat_old,
  input  logic       wr_beat_now,
  output logic [1:0] st_o,
  output logic       rdl_clr_o,
  output logic       ap_pend_o,
  output logic       ap_start_o
);
  localparam int RW = (TRDL < 2) ? 1 : $clog2(TRDL + 1);
  localparam int PW = $clog2(TRP + 1);

  bank_st_e      st_q;
  logic [RW-1:0] rdl_q;
  logic [PW-1:0] prc_q;
  logic          pend_q, ap_start;

  // internal precharge begins once the burst is off the bus and write recovery is done
  assign ap_start = pend_q && !beat_old && (rdl_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      prc_q  <= '0;
      rdl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (act_go) begin
        st_q <= BK_ACTIVE;
      end else if ((pre_go && st_q == BK_ACTIVE) || ap_start) begin
        st_q  <= BK_PRECH;
        prc_q <= PW'(TRP - 1);
      end else if (st_q == BK_PRECH) begin
        if (prc_q <= PW'(1)) begin
          st_q  <= BK_IDLE;
          prc_q <= '0;
        end else begin
          prc_q <= prc_q - PW'(1);
        end
      end

      if (col_go && col_ap) pend_q <= 1'b1;
      else if (ap_start)    pend_q <= 1'b0;

      if (wr_beat_now)        rdl_q <= RW'(TRDL - 1);
      else if (rdl_q != '0)   rdl_q <= rdl_q - RW'(1);
    end
  end

  assign st_o       = st_q;
  assign rdl_clr_o  = (rdl_q == '0);
  assign ap_pend_o  = pend_q;
  assign ap_start_o = ap_start;
endmodule

// File: rtl/sdram_pre_sched.sv
module sdram_pre_sched
  import pre_sched_pkg::*;
#(
  parameter int NB   = 4,
  parameter int TRDL = 2,
  parameter int TRP  = 3,
  localparam int BW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cas_lat3,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [BW-1:0] req_bank,
  input  logic          req_ap,
  output logic          req_ready,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [BW-1:0] cmd_bank,
  output logic          cmd_ap,
  output logic          trunc_valid,
  output logic [1:0]    trunc_beats
);
  logic [NB-1:0][1:0] bank_st;
  logic [NB-1:0]      rdl_clr, ap_pend, ap_start, wr_beat, old_wr_beat;
  logic [1:0]         b_left;
  logic [BW-1:0]      b_bank;
  logic               b_wr, b_ap, b_busy, trunc_hit;
  logic               go, is_col, col_go, pre_go, col_block;

  assign is_col    = (req_op == OP_RD) || (req_op == OP_WR);
  assign b_busy    = (b_left != 2'd0);
  assign col_block = |(ap_pend & ~ap_start);

  always_comb begin
    unique case (op_e'(req_op))
      OP_ACT:  req_ready = (bank_st[req_bank] == BK_IDLE);
      OP_RD,
      OP_WR:   req_ready = (bank_st[req_bank] == BK_ACTIVE) && !col_block;
      OP_PRE:  req_ready = (bank_st[req_bank] != BK_PRECH) && !ap_pend[req_bank]
                           && rdl_clr[req_bank] && !old_wr_beat[req_bank];
      default: req_ready = 1'b0;
    endcase
  end

  assign go     = req_valid && req_ready;
  assign col_go = go && is_col;
  assign pre_go = go && (req_op == OP_PRE);

  pre_burst_trk #(.BW(BW)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .col_go(col_go), .col_wr(req_op == OP_WR), .col_ap(req_ap), .col_bank(req_bank),
    .pre_go(pre_go), .pre_bank(req_bank),
    .left_o(b_left), .bank_o(b_bank), .wr_o(b_wr), .ap_o(b_ap), .trunc_hit(trunc_hit)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit, beat_old;
    assign hit            = (req_bank == BW'(b));
    assign beat_old       = b_busy && (b_bank == BW'(b));
    assign old_wr_beat[b] = beat_old && b_wr;
    // an accepted column command takes the bus, so the old burst loses this beat
    assign wr_beat[b]     = (old_wr_beat[b] && !col_go) || (col_go && hit && req_op == OP_WR);

    pre_bank_trk #(.TRDL(TRDL), .TRP(TRP)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_go(go && hit && req_op == OP_ACT),
      .pre_go(pre_go && hit),
      .col_go(col_go && hit),
      .col_ap(req_ap),
      .beat_old(beat_old),
      .wr_beat_now(wr_beat[b]),
      .st_o(bank_st[b]),
      .rdl_clr_o(rdl_clr[b]),
      .ap_pend_o(ap_pend[b]),
      .ap_start_o(ap_start[b])
    );
  end

  assign cmd_valid   = go;
  assign cmd_op      = req_op;
  assign cmd_bank    = req_bank;
  assign cmd_ap      = req_ap && is_col;
  assign trunc_valid = trunc_hit;
  assign trunc_beats = trunc_hit ? kept_beats(beats_done(b_left), cas_lat3) : 2'd0;
endmodule

// File: rtl/pre_sched_chk.sv
module pre_sched_chk
  import pre_sched_pkg::*;
#(
  parameter int NB   = 4,
  parameter int TRDL = 2,
  parameter int TRP  = 3,
  localparam int BW  = $clog2(NB)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cas_lat3,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [BW-1:0]      cmd_bank,
  input logic               trunc_valid,
  input logic [1:0]         trunc_beats,
  input logic [NB-1:0][1:0] bank_st,
  input logic [NB-1:0]      ap_start,
  input logic [NB-1:0]      wr_beat,
  input logic [1:0]         b_left,
  input logic               b_ap
);
  logic is_col;
  assign is_col = cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR);

  AST_COL_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> bank_st[cmd_bank] == BK_ACTIVE);  // R3
  AST_ACT_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT) |-> bank_st[cmd_bank] == BK_IDLE);  // R2
  AST_NO_COL_IN_AP: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !(b_left != 2'd0 && b_ap));  // R9
  AST_TRUNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_valid |-> (trunc_beats != 2'd0) && (trunc_beats <= (cas_lat3 ? 2'd2 : 2'd1)));  // R6
  AST_TRUNC_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_valid |-> cmd_valid && cmd_op == OP_PRE);  // R6

  for (genvar b = 0; b < NB; b++) begin : g_win
    int since_w, since_p;
    logic pre_here, act_here;
    assign pre_here = cmd_valid && cmd_op == OP_PRE && cmd_bank == BW'(b);
    assign act_here = cmd_valid && cmd_op == OP_ACT && cmd_bank == BW'(b);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_w <= TRDL;
        since_p <= TRP;
      end else begin
        if (wr_beat[b])          since_w <= 0;
        else if (since_w < TRDL) since_w <= since_w + 1;
        if ((pre_here && bank_st[b] == BK_ACTIVE) || ap_start[b]) since_p <= 0;
        else if (since_p < TRP) since_p <= since_p + 1;
      end
    end

    AST_RDL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      pre_here |-> since_w >= TRDL - 1);  // R4
    AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      act_here |-> since_p >= TRP - 1);  // R5
  end
endmodule

bind sdram_pre_sched pre_sched_chk #(.NB(NB), .TRDL(TRDL), .TRP(TRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
  .trunc_valid(trunc_valid), .trunc_beats(trunc_beats),
  .bank_st(bank_st), .ap_start(ap_start), .wr_beat(wr_beat),
  .b_left(b_left), .b_ap(b_ap)
);

// File: tb/sdram_pre_sched_tb.sv
module sdram_pre_sched_tb;
  localparam int NB = 4, TRDL = 2, TRP = 3;

  logic       clk = 1'b0, rst_n = 1'b0, cas_lat3 = 1'b0;
  logic       req_valid = 1'b0, req_ap = 1'b0;
  logic [1:0] req_op = 2'b00, req_bank = 2'b00;
  logic       req_ready, cmd_valid, cmd_ap, trunc_valid;
  logic [1:0] cmd_op, cmd_bank, trunc_beats;

  always #10 clk = ~clk;  // 50 MHz

  sdram_pre_sched #(.NB(NB), .TRDL(TRDL), .TRP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_ap(req_ap),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_ap(cmd_ap), .trunc_valid(trunc_valid), .trunc_beats(trunc_beats)
  );

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model: absolute cycle numbers per bank
  int now = 0;
  int mst[NB];   // 0 idle, 1 open, 2 precharging
  int pst[NB];   // cycle precharge began
  int lastw[NB]; // cycle of last write beat
  bit apf[NB];   // auto-precharge pending
  int bs = -100, be = -100, bb = 0;
  bit bw = 0;

  task automatic step(input bit v, input int op, input int bk, input bit ap, output bit acc);
    bit in_burst, colblk, er, et, is_col;
    bit aps[NB];
    int eb, cap;
    @(negedge clk);
    req_valid = v; req_op = 2'(op); req_bank = 2'(bk); req_ap = ap;
    #1;
    for (int b = 0; b < NB; b++)
      if (mst[b] == 2 && now - pst[b] >= TRP) mst[b] = 0;
    in_burst = (now > bs) && (now <= be);
    colblk = 0;
    for (int b = 0; b < NB; b++) begin
      aps[b] = apf[b] && !(in_burst && bb == b) && (now - lastw[b] >= TRDL);
      if (apf[b] && !aps[b]) colblk = 1;
    end
    is_col = (op == 1 || op == 2);
    case (op)
      0: er = (mst[bk] == 0);
      1, 2: er = (mst[bk] == 1) && !colblk;
      default: er = (mst[bk] != 2) && !apf[bk] && !(in_burst && bw && bb == bk)
                    && (now - lastw[bk] >= TRDL);
    endcase
    acc = v && er;
    et = acc && op == 3 && in_burst && !bw && bb == bk;
    cap = cas_lat3 ? 2 : 1;
    eb = (now - bs < cap) ? now - bs : cap;
    vectors++;
    if (req_ready !== er) begin
      miscompares++;
      $display("FAIL %s cyc %0d op %0d bank %0d: req_ready %b expected %b", cur_req, now, op, bk, req_ready, er);
    end
    if (cmd_valid !== acc || (acc && (cmd_op !== 2'(op) || cmd_bank !== 2'(bk) || cmd_ap !== (ap && is_col)))) begin
      miscompares++;
      $display("FAIL R11 cyc %0d: cmd %b/%0d/%0d/%b expected %b/%0d/%0d/%b", now,
               cmd_valid, cmd_op, cmd_bank, cmd_ap, acc, op, bk, ap && is_col);
    end
    if (trunc_valid !== et || (et && trunc_beats !== 2'(eb))) begin
      miscompares++;
      $display("FAIL R6 cyc %0d: trunc %b/%0d expected %b/%0d", now, trunc_valid, trunc_beats, et, eb);
    end
    @(posedge clk);
    // model update for this cycle
    if (acc && op == 2) lastw[bk] = now;
    else if (in_burst && bw && !(acc && is_col)) lastw[bb] = now;
    for (int b = 0; b < NB; b++)
      if (aps[b]) begin mst[b] = 2; pst[b] = now; apf[b] = 0; end
    if (acc) begin
      if (op == 0) mst[bk] = 1;
      else if (op == 3) begin
        if (mst[bk] == 1) begin mst[bk] = 2; pst[bk] = now; end
        if (et) be = now - 1;
      end else begin
        bs = now; be = now + 3; bb = bk; bw = (op == 2);
        if (ap) apf[bk] = 1;
      end
    end
    now++;
  endtask

  task automatic put(input int op, input int bk, input bit ap, input int maxc);
    bit acc = 0;
    for (int i = 0; i < maxc && !acc; i++) step(1, op, bk, ap, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, acc);
  endtask

  task automatic directed();
    cur_req = "R2"; put(0, 0, 0, 12); put(0, 0, 0, 3);
    cur_req = "R3"; put(1, 1, 0, 3); put(0, 1, 0, 12); put(2, 1, 0, 12);
    cur_req = "R4"; put(3, 1, 0, 12);
    cur_req = "R5"; put(0, 1, 0, 12);
    cur_req = "R6"; put(1, 0, 0, 12); put(3, 0, 0, 12);
    put(0, 0, 0, 12); put(1, 0, 0, 12); idle(2); put(3, 0, 0, 12);
    put(0, 0, 0, 12); put(1, 0, 0, 12); idle(1); put(3, 0, 0, 12);
    cur_req = "R7"; put(0, 0, 0, 12); put(0, 2, 0, 12); put(1, 2, 1, 12);
    cur_req = "R9"; put(1, 0, 0, 12);
    cur_req = "R7"; put(0, 2, 0, 12);
    cur_req = "R8"; put(2, 2, 1, 12);
    cur_req = "R9"; put(2, 0, 0, 12);
    cur_req = "R8"; put(0, 2, 0, 12);
    cur_req = "R10"; put(0, 3, 0, 12); put(1, 3, 1, 12); put(3, 3, 0, 4);
    put(3, 1, 0, 12); put(3, 1, 0, 12); put(0, 1, 0, 12);
    put(0, 3, 0, 12); put(3, 3, 0, 12); put(3, 3, 0, 12);
    cur_req = "R12"; put(0, 3, 0, 12); put(2, 0, 0, 12); put(1, 2, 0, 12); put(3, 0, 0, 12);
    put(0, 0, 0, 12); put(2, 0, 0, 12); idle(1); put(2, 3, 0, 12); put(3, 0, 0, 12);
    idle(6);
  endtask

  task automatic random_run(input int n);
    bit acc;
    cur_req = "R11";
    for (int i = 0; i < n; i++)
      step(($urandom % 10) < 8, $urandom % 4, $urandom % NB, ($urandom % 4) == 0, acc);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      mst[b] = 0; pst[b] = -100; lastw[b] = -100; apf[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: after reset reads are held off, activates are ready
    cur_req = "R1";
    begin
      bit acc;
      step(1, 1, 0, 0, acc);
      step(1, 2, 3, 0, acc);
      step(0, 0, 2, 0, acc);
    end
    cas_lat3 = 1'b0; directed(); random_run(2500);
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin
      mst[b] = 0; pst[b] = -100; lastw[b] = -100; apf[b] = 0;
    end
    bs = -100; be = -100; now = now + 2;
    cas_lat3 = 1'b1; directed(); random_run(2500);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run still going, expected to finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule